// File: doc/BRIEF.md
# Link Self-Test Controller

This block runs a built-in self test on a serial link receiver. A test session is opened by an enable input and closed by removing it. Enable and test clock source come from two pins by default; a control register on a small address/data bus can take over both. The block turns the chosen source into a clock-enable strobe for the test logic, counts received test frames that carry an error flag, and drives a pass/fail status pin.

While a session runs, the status pin idles high. Each errored frame pulls it low for the low half of one clock period, so a string of bad frames shows up as a string of separate pulses that can be counted outside the chip. When the session ends, the pin holds the result of that session: high when no errored frame was seen, low otherwise. The result stays until a new session starts, a reset occurs, or the receiver loses lock. The errored-frame count can be read over the register bus.

Top module: `link_bist_ctrl`

## Requirements
- R1: After reset, pass_o is high in both clock phases, and register reads at 0x24 and 0x25 both return 0.
- R2: Control register 0x24 uses these bits: bit 0 selects register configuration, bit 1 is the enable and bits 3:2 are the source. While bit 0 is 0, the pins bist_en_i and src_sel_i set the configuration. While bit 0 is 1, the register fields set it and the pins are ignored. A read of 0x24 returns the last value written.
- R3: The source code drives clk_src_o and sets the rate of test_tick_o. Code 0 is the external clock, with a tick every cycle. Code 1 gives one tick in 2 cycles, code 2 one tick in 4 cycles, and code 3 one tick in 8 cycles.
- R4: During a session, a frame_vld_i cycle with frame_err_i high drives pass_o low during the low phase of the next clock cycle. pass_o stays high during that cycle's high phase.
- R5: Errored frames in consecutive cycles give separate low pulses, with pass_o high between them. A valid frame with frame_err_i low gives no pulse.
- R6: Register 0x25 returns the number of errored frames in the current or last session. The count saturates at 255.
- R7: A rising effective enable starts a new session and clears the count to 0.
- R8: After the enable falls, pass_o shows high if the count is 0 and low otherwise. It holds that value until the next session, where it idles high, or until a reset.
- R9: When lock_i is low outside a session, the held result is dropped and pass_o returns high.
- R10: Writes to 0x25 are ignored. Reads of any address other than 0x24 and 0x25 return 0.
- R11: Frame strobes outside a session change neither the count nor pass_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bist_en_i | input | 1 | Test enable pin |
| src_sel_i | input | 2 | Test clock source pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| frame_vld_i | input | 1 | One-cycle strobe marking a received test frame |
| frame_err_i | input | 1 | Error flag for the frame in the same cycle |
| lock_i | input | 1 | Receiver lock indication |
| pass_o | output | 1 | Pass/fail status pin |
| clk_src_o | output | 2 | Selected test clock source |
| test_tick_o | output | 1 | Test clock enable strobe |

## Verification
Two pairs of events can meet in one cycle. The first pair is the error pulse from a previous frame and the next frame's strobe. Every frame pattern is streamed back to back, so each low-phase sample of pass_o overlaps the capture of the next frame, and each sample is compared with the error bit of the frame before it. The second pair is the session boundary and status handling. After each run, the bench checks the held result against the popcount of the pattern, checks that stray strobes and writes to 0x25 leave it unchanged, and checks that it is released on lock loss and on restart.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_DIV2 = 2'd1,
    SRC_DIV4 = 2'd2,
    SRC_DIV8 = 2'd3
  } clk_src_e;

  localparam int unsigned CTL_OVR_BIT = 0;
  localparam int unsigned CTL_EN_BIT  = 1;
  localparam int unsigned CTL_SRC_LSB = 2;
endpackage

// File: rtl/lb_cfg_regs.sv
module lb_cfg_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pin_en_i,
  input  logic [1:0]        pin_src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [1:0]        src_o
);
  import link_bist_pkg::*;

  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (we_i && addr_i == CTRL_ADDR) ctrl_q <= wdata_i;
  end

  always_comb begin
    if (ctrl_q[CTL_OVR_BIT]) begin
      en_o  = ctrl_q[CTL_EN_BIT];
      src_o = ctrl_q[CTL_SRC_LSB +: 2];
    end else begin
      en_o  = pin_en_i;
      src_o = pin_src_i;
    end
  end

  always_comb begin
    if (addr_i == CTRL_ADDR)      rdata_o = ctrl_q;
    else if (addr_i == STAT_ADDR) rdata_o = DATA_W'(cnt_i);
    else                          rdata_o = '0;
  end
endmodule

// File: rtl/lb_tick_gen.sv
module lb_tick_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_i,
  output logic       tick_o
);
  import link_bist_pkg::*;

  localparam int unsigned DIV_W = 3;  // deepest ratio is 8

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (clk_src_e'(src_i))
      SRC_EXT:  tick_o = 1'b1;
      SRC_DIV2: tick_o = div_q[0];
      SRC_DIV4: tick_o = &div_q[1:0];
      SRC_DIV8: tick_o = &div_q;
      default:  tick_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lb_err_track.sv
module lb_err_track #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lock_i,
  input  logic             vld_i,
  input  logic             err_i,
  output logic             run_o,
  output logic             start_o,
  output logic             hit_q_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             held_o,
  output logic             result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q, hit_q, held_q, result_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, stop, hit;

  assign start = en_i & ~run_q;
  assign stop  = ~en_i & run_q;
  assign hit   = run_q & vld_i & err_i;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                       cnt_d = '0;
    else if (hit && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      hit_q    <= 1'b0;
      cnt_q    <= '0;
      held_q   <= 1'b0;
      result_q <= 1'b1;
    end else begin
      run_q <= en_i;
      hit_q <= hit;
      cnt_q <= cnt_d;
      if (start) begin
        held_q <= 1'b0;
      end else if (stop) begin
        held_q   <= 1'b1;
        result_q <= (cnt_d == '0);
      end else if (!run_q && !lock_i) begin
        held_q <= 1'b0;
      end
    end
  end

  assign run_o    = run_q;
  assign start_o  = start;
  assign hit_q_o  = hit_q;
  assign cnt_o    = cnt_q;
  assign held_o   = held_q;
  assign result_o = result_q;
endmodule

// File: rtl/lb_pass_drv.sv
module lb_pass_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic held_i,
  input  logic result_i,
  input  logic hit_q_i,
  output logic pass_o
);
  logic neg_q;
  logic level;

  // qualifier moves on the falling edge so the gate opens for the low phase only
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= hit_q_i;
  end

  assign level  = run_i ? 1'b1 : (held_i ? result_i : 1'b1);
  assign pass_o = level & ~(neg_q & ~clk_i);
endmodule

// File: rtl/link_bist_ctrl.sv
module link_bist_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bist_en_i,
  input  logic [1:0]        src_sel_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_vld_i,
  input  logic              frame_err_i,
  input  logic              lock_i,
  output logic              pass_o,
  output logic [1:0]        clk_src_o,
  output logic              test_tick_o
);
  logic             en_w;
  logic [1:0]       src_w;
  logic             run_w, start_w, hit_q_w, held_w, result_w;
  logic [CNT_W-1:0] cnt_w;

  lb_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .pin_en_i (bist_en_i),
    .pin_src_i(src_sel_i),
    .cnt_i    (cnt_w),
    .rdata_o  (reg_rdata_o),
    .en_o     (en_w),
    .src_o    (src_w)
  );

  lb_tick_gen u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_w),
    .tick_o(test_tick_o)
  );

  lb_err_track #(.CNT_W(CNT_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_w),
    .lock_i  (lock_i),
    .vld_i   (frame_vld_i),
    .err_i   (frame_err_i),
    .run_o   (run_w),
    .start_o (start_w),
    .hit_q_o (hit_q_w),
    .cnt_o   (cnt_w),
    .held_o  (held_w),
    .result_o(result_w)
  );

  lb_pass_drv u_pass (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .held_i  (held_w),
    .result_i(result_w),
    .hit_q_i (hit_q_w),
    .pass_o  (pass_o)
  );

  assign clk_src_o = src_w;
endmodule

// File: rtl/link_bist_ctrl_chk.sv
module link_bist_ctrl_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_w,
  input logic             start_w,
  input logic             held_w,
  input logic             result_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             frame_vld_i,
  input logic             frame_err_i,
  input logic             lock_i,
  input logic [1:0]       clk_src_o,
  input logic             test_tick_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3
  ext_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_src_o == 2'd0 |-> test_tick_o);

  // R6
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w && frame_vld_i && frame_err_i && cnt_w != CNT_MAX
    |=> cnt_w == CNT_W'($past(cnt_w) + 1'b1));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w == CNT_MAX && !start_w |=> cnt_w == CNT_MAX);

  // R7
  session_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> cnt_w == '0);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_w && !run_w && !start_w && lock_i |=> held_w && $stable(result_w));

  // R9
  unlock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w && !lock_i |=> !held_w);

  // R11
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w && !start_w |=> $stable(cnt_w));
endmodule

bind link_bist_ctrl link_bist_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_w      (run_w),
  .start_w    (start_w),
  .held_w     (held_w),
  .result_w   (result_w),
  .cnt_w      (cnt_w),
  .frame_vld_i(frame_vld_i),
  .frame_err_i(frame_err_i),
  .lock_i     (lock_i),
  .clk_src_o  (clk_src_o),
  .test_tick_o(test_tick_o)
);

// File: tb/tb_link_bist_ctrl.sv
`timescale 1ns/1ps
module tb_link_bist_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bist_en_i = 1'b0;
  logic [1:0] src_sel_i = 2'd0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h25;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       frame_vld_i = 1'b0;
  logic       frame_err_i = 1'b0;
  logic       lock_i = 1'b1;
  logic       pass_o;
  logic [1:0] clk_src_o;
  logic       test_tick_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic hi_s, lo_s, tick_s;

  always #10 clk_i = ~clk_i;

  link_bist_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bist_en_i(bist_en_i), .src_sel_i(src_sel_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .frame_vld_i(frame_vld_i), .frame_err_i(frame_err_i),
    .lock_i(lock_i), .pass_o(pass_o), .clk_src_o(clk_src_o), .test_tick_o(test_tick_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at posedge+2; samples high phase (+6), low phase (+16), returns at next posedge+2
  task automatic cyc();
    #4 hi_s = pass_o; tick_s = test_tick_o;
    #10 lo_s = pass_o;
    @(posedge clk_i); #2;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr_i = a; #1 v = reg_rdata_o;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [5];
    int ticks, pop;
    pats[0] = 8'h00; pats[1] = 8'h01; pats[2] = 8'h03; pats[3] = 8'hA5; pats[4] = 8'hFF;

    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 pass high phase", hi_s, 1);
    chk("R1 pass low phase", lo_s, 1);
    rd(8'h24, v); chk("R1 ctrl reads 0", v, 0);
    rd(8'h25, v); chk("R1 count reads 0", v, 0);

    // R3 source sweep
    for (int s = 0; s < 4; s++) begin
      src_sel_i = 2'(s);
      ticks = 0;
      for (int k = 0; k < 16; k++) begin
        cyc();
        ticks += int'(tick_s);
      end
      chk("R3 clk_src_o", clk_src_o, s);
      chk("R3 tick count over 16", ticks, 16 >> s);
    end
    src_sel_i = 2'd0;

    // R4 R5 R6 R7 R8 R11 pattern sweep
    for (int p = 0; p < 5; p++) begin
      pop = $countones(pats[p]);
      bist_en_i = 1'b1;
      cyc();
      rd(8'h25, v); chk("R7 count cleared at start", v, 0);
      for (int i = 0; i <= 8; i++) begin
        if (i < 8) begin frame_vld_i = 1'b1; frame_err_i = pats[p][i]; end
        else begin frame_vld_i = 1'b0; frame_err_i = 1'b0; end
        cyc();
        chk("R4 high phase stays high", hi_s, 1);
        chk("R5 low phase pulse", lo_s, (i > 0 && pats[p][i-1]) ? 0 : 1);
      end
      rd(8'h25, v); chk("R6 errored frame count", v, pop);
      bist_en_i = 1'b0;
      cyc(); cyc();
      chk("R8 held result high phase", hi_s, pop == 0 ? 1 : 0);
      chk("R8 held result low phase", lo_s, pop == 0 ? 1 : 0);
      frame_vld_i = 1'b1; frame_err_i = 1'b1;
      cyc();
      frame_vld_i = 1'b0; frame_err_i = 1'b0;
      cyc();
      chk("R11 no pulse outside run", lo_s, pop == 0 ? 1 : 0);
      rd(8'h25, v); chk("R11 count unchanged outside run", v, pop);
    end

    // R9 lock loss releases the failing result (last pattern failed)
    lock_i = 1'b0;
    cyc(); cyc();
    chk("R9 pass high after lock loss", hi_s, 1);
    lock_i = 1'b1;
    cyc();

    // R6 saturation
    bist_en_i = 1'b1;
    cyc();
    frame_vld_i = 1'b1; frame_err_i = 1'b1;
    repeat (300) cyc();
    frame_vld_i = 1'b0; frame_err_i = 1'b0;
    cyc();
    rd(8'h25, v); chk("R6 count saturates", v, 255);
    // R10
    wr(8'h25, 8'h00);
    rd(8'h25, v); chk("R10 status write ignored", v, 255);
    rd(8'h30, v); chk("R10 unmapped read zero", v, 0);
    bist_en_i = 1'b0;
    cyc(); cyc();
    chk("R8 saturated run fails", hi_s, 0);
    bist_en_i = 1'b1;
    cyc(); cyc();
    rd(8'h25, v); chk("R7 new session clears count", v, 0);
    chk("R8 idles high during new run", lo_s, 1);
    bist_en_i = 1'b0;
    cyc(); cyc();

    // R2 register takes over: ovr=1, en=0, src=2 while pins say en=1, src=1
    src_sel_i = 2'd1;
    wr(8'h24, 8'h09);
    bist_en_i = 1'b1;
    cyc();
    chk("R2 source from register", clk_src_o, 2);
    rd(8'h24, v); chk("R2 ctrl readback", v, 8'h09);
    frame_vld_i = 1'b1; frame_err_i = 1'b1;
    cyc();
    frame_vld_i = 1'b0; frame_err_i = 1'b0;
    cyc();
    rd(8'h25, v); chk("R2 pin enable ignored", v, 0);
    wr(8'h24, 8'h0B);
    cyc();
    frame_vld_i = 1'b1; frame_err_i = 1'b1;
    cyc();
    frame_vld_i = 1'b0; frame_err_i = 1'b0;
    cyc();
    rd(8'h25, v); chk("R2 register enable runs", v, 1);
    wr(8'h24, 8'h00);
    chk("R2 pins back in control", clk_src_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule